// File: doc/BRIEF.md
# Forwarded-Transaction Termination Handler

This block follows a single transaction that a bus bridge has accepted from an initiator and now re-issues on the far (target-side) bus. After each attempt, the target-side logic reports how the attempt ended. The handler turns that report into one of four results: a request to try again, removal of the entry, discard of posted data, or a completion held for the initiator's next repeat.

Delayed reads and delayed writes are completed back to the initiator. The next time the initiator repeats the transaction, the handler either claims it and hands over the stored termination, or it deliberately leaves the repeat unclaimed. An unclaimed repeat carries a master abort back to the initiator. Posted writes are fire-and-forget: they end at the target side and are never repeated. A configuration access that was turned into a special cycle expects a master abort, so that abort is treated as normal success.

Retries are bounded. A counter allows either 2^SHORT_LOG2 or 2^LONG_LOG2 attempts, and the choice is made per transaction. Master aborts set sticky per-bus status bits that are cleared by writing one. A qualifying master abort on a posted write also produces a one-cycle system-error pulse.

Top module: `fwd_term_handler`

## Requirements
- R1: After reset the block is idle. `busy`, `rpt_claim` and every pulse output are low, and both status bits are clear.
- R2: `load` is accepted only while idle. It clears the retry count and latches `load_kind`, `load_tgt_pri` and `load_long`. A `load` while busy has no effect. The kind encodings are 0 delayed read, 1 delayed write, 2 posted write, and 3 special cycle converted from a configuration access.
- R3: A retry response (termination code 1) pulses `retry_req` one cycle after the response. The exception is the last allowed attempt. The retry response that brings the count to the limit (8 with `load_long`=0 and 16 with `load_long`=1 in the bench configuration) pulses `retry_limit_hit` and `entry_remove` instead, and the block goes idle.
- R4: For a delayed read or write, a normal (code 0), disconnect (code 2) or target-abort (code 3) response holds the entry. The next repeat is claimed, and `rpt_result` equals that code. `entry_remove` pulses one cycle after the repeat.
- R5: For a delayed read or write, a master abort (code 4) holds the entry. The next repeat is not claimed, and `rpt_result` reads 4. The entry is removed after that repeat.
- R6: For a posted write, codes 0, 2 and 3 remove the entry at once. Code 4 pulses `post_discard` together with `entry_remove`, and no further retry is requested.
- R7: A master abort on any kind except the special cycle sets the status bit of the target-side bus. That is `sts_rma_pri` when `load_tgt_pri`=1, and `sts_rma_sec` otherwise. The bits are sticky. A `sts_clr_*` pulse clears them, and a new setting event in the same cycle wins over the clear.
- R8: `serr_pulse` is high for exactly one cycle after a posted-write master abort, and only when `ctl_ma_mode`=1, `ctl_serr_en`=1 and `ctl_ma_post_dis`=0. It never pulses for other kinds.
- R9: A master abort on a special cycle sets no status bit. The repeat is claimed with `rpt_result` = 2 (disconnect after the first data phase).
- R10: While an attempt is outstanding, a repeat is claimed with `rpt_result` = 1 (retry). While idle, `rpt_claim` is low.
- R11: `term_valid` has no effect while idle or while a completion is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Start tracking a new transaction |
| load_kind | input | 2 | Transaction kind (R2 encoding) |
| load_tgt_pri | input | 1 | 1 when the target-side bus is the primary bus |
| load_long | input | 1 | Select the long retry limit |
| term_valid | input | 1 | Target-side termination report is valid |
| term_code | input | 3 | 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| rpt_valid | input | 1 | Initiator repeats the transaction |
| ctl_ma_mode | input | 1 | Master-abort mode control |
| ctl_serr_en | input | 1 | System-error enable |
| ctl_ma_post_dis | input | 1 | Suppress system error on posted-write master abort |
| sts_clr_pri | input | 1 | Write-one clear of primary status bit |
| sts_clr_sec | input | 1 | Write-one clear of secondary status bit |
| busy | output | 1 | An entry is being tracked |
| retry_req | output | 1 | Pulse: re-issue the transaction |
| entry_remove | output | 1 | Pulse: entry leaves the queue |
| post_discard | output | 1 | Pulse: posted data dropped |
| retry_limit_hit | output | 1 | Pulse: retry limit reached |
| rpt_claim | output | 1 | A repeat in this cycle would be claimed |
| rpt_result | output | 3 | Termination given to a repeat (code encoding) |
| sts_rma_pri | output | 1 | Sticky master-abort-received, primary bus |
| sts_rma_sec | output | 1 | Sticky master-abort-received, secondary bus |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
The bench drives the retry counter to exactly the limit at both settings. An off-by-one counter would either issue one retry too many or drop the entry one attempt early. It covers master aborts on every kind, which catches three faults: a delayed abort that is still claimed, a posted abort that keeps retrying, and a special cycle that wrongly sets status. It walks the eight combinations of the three system-error gate bits, so a pulse with one gate missing shows up. It also drives a clear in the same cycle as a new abort, sends a `load` and a termination at times when both must be ignored, and checks that a repeat arriving while an attempt is still outstanding is answered with retry.

// File: rtl/fth_pkg.sv
// Package: shared encodings for the forwarded-transaction termination handler.
// Assumes codes 5..7 of the termination field are never driven by a correct source.
package fth_pkg;
    typedef enum logic [1:0] {
        TX_DRD = 2'd0,
        TX_DWR = 2'd1,
        TX_PWR = 2'd2,
        TX_SPC = 2'd3
    } tx_kind_e;

    typedef enum logic [2:0] {
        TC_NORMAL = 3'd0,
        TC_RETRY  = 3'd1,
        TC_DISC   = 3'd2,
        TC_TABORT = 3'd3,
        TC_MABORT = 3'd4
    } term_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } ent_state_e;
endpackage

// File: rtl/fth_retry_ctr.sv
// Module: bounded retry counter with a per-transaction limit select.
// Counts target retries of the current entry and reports when the next
// retry is the last one allowed. Assumes inc is never raised while at_limit.
module fth_retry_ctr #(
    parameter int SHORT_LOG2 = 24,
    parameter int LONG_LOG2  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_long_in,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = LONG_LOG2;
    localparam logic [CNT_W-1:0] LIM_LONG  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);

    logic [CNT_W-1:0] cnt_q;
    logic             sel_long_q;
    logic [CNT_W-1:0] lim_m1;

    generate
        if (SHORT_LOG2 == LONG_LOG2) begin : g_one_limit
            // Single limit when both settings coincide
            assign lim_m1 = LIM_LONG;
        end else begin : g_two_limits
            // Pick the latched limit
            assign lim_m1 = sel_long_q ? LIM_LONG : LIM_SHORT;
        end
    endgenerate

    // Counter and limit-select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sel_long_q <= 1'b0;
        end else if (clr) begin
            cnt_q      <= '0;
            sel_long_q <= sel_long_in;
        end else if (inc) begin
            cnt_q      <= cnt_q + 1'b1;
        end
    end

    // Last allowed attempt detection
    assign at_limit = (cnt_q == lim_m1);

    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_m1);
    a_r2_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/fth_decider.sv
// Module: entry state machine turning each target-side termination into an
// initiator-side result. Outputs are registered one-cycle pulses, except the
// repeat response, which reflects the current state. Master-abort events are
// combinational strobes for the status block.
module fth_decider (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] load_kind,
    input  logic       load_tgt_pri,
    input  logic       term_valid,
    input  logic [2:0] term_code,
    input  logic       rpt_valid,
    input  logic       at_limit,
    output logic       ctr_clr,
    output logic       ctr_inc,
    output logic       busy,
    output logic       retry_req,
    output logic       entry_remove,
    output logic       post_discard,
    output logic       retry_limit_hit,
    output logic       rpt_claim,
    output logic [2:0] rpt_result,
    output logic       ev_ma_pri,
    output logic       ev_ma_sec,
    output logic       ev_ma_post
);
    import fth_pkg::*;

    ent_state_e st_q, st_n;
    tx_kind_e   kind_q;
    logic       tgt_pri_q;
    logic       hold_claim_q, hold_claim_n;
    term_code_e hold_res_q, hold_res_n;
    logic       n_retry, n_remove, n_discard, n_limit, ev_ma;
    term_code_e code;

    assign code    = term_code_e'(term_code);
    assign ctr_clr = load && (st_q == ST_IDLE);

    // Next-state and pulse decision for terminations and repeats
    always_comb begin
        st_n         = st_q;
        hold_claim_n = hold_claim_q;
        hold_res_n   = hold_res_q;
        n_retry      = 1'b0;
        n_remove     = 1'b0;
        n_discard    = 1'b0;
        n_limit      = 1'b0;
        ev_ma        = 1'b0;
        ev_ma_post   = 1'b0;
        ctr_inc      = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (load) st_n = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (term_valid) begin
                    case (code)
                        TC_RETRY: begin
                            if (at_limit) begin
                                n_limit  = 1'b1;
                                n_remove = 1'b1;
                                st_n     = ST_IDLE;
                            end else begin
                                n_retry  = 1'b1;
                                ctr_inc  = 1'b1;
                            end
                        end
                        TC_MABORT: begin
                            if (kind_q == TX_SPC) begin
                                st_n         = ST_HOLD;
                                hold_claim_n = 1'b1;
                                hold_res_n   = TC_DISC;
                            end else if (kind_q == TX_PWR) begin
                                n_discard  = 1'b1;
                                n_remove   = 1'b1;
                                ev_ma      = 1'b1;
                                ev_ma_post = 1'b1;
                                st_n       = ST_IDLE;
                            end else begin
                                ev_ma        = 1'b1;
                                st_n         = ST_HOLD;
                                hold_claim_n = 1'b0;
                                hold_res_n   = TC_MABORT;
                            end
                        end
                        TC_NORMAL, TC_DISC, TC_TABORT: begin
                            if (kind_q == TX_PWR) begin
                                n_remove = 1'b1;
                                st_n     = ST_IDLE;
                            end else begin
                                st_n         = ST_HOLD;
                                hold_claim_n = 1'b1;
                                hold_res_n   = code;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_HOLD: begin
                if (rpt_valid) begin
                    n_remove = 1'b1;
                    st_n     = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Entry registers: state, latched attributes, held completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            kind_q       <= TX_DRD;
            tgt_pri_q    <= 1'b0;
            hold_claim_q <= 1'b0;
            hold_res_q   <= TC_NORMAL;
        end else begin
            st_q         <= st_n;
            hold_claim_q <= hold_claim_n;
            hold_res_q   <= hold_res_n;
            if (ctr_clr) begin
                kind_q    <= tx_kind_e'(load_kind);
                tgt_pri_q <= load_tgt_pri;
            end
        end
    end

    // Registered one-cycle result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_req       <= 1'b0;
            entry_remove    <= 1'b0;
            post_discard    <= 1'b0;
            retry_limit_hit <= 1'b0;
        end else begin
            retry_req       <= n_retry;
            entry_remove    <= n_remove;
            post_discard    <= n_discard;
            retry_limit_hit <= n_limit;
        end
    end

    // Repeat response and status strobes
    assign busy       = (st_q != ST_IDLE);
    assign rpt_claim  = (st_q == ST_ISSUE) || ((st_q == ST_HOLD) && hold_claim_q);
    assign rpt_result = (st_q == ST_HOLD) ? 3'(hold_res_q) : 3'(TC_RETRY);
    assign ev_ma_pri  = ev_ma && tgt_pri_q;
    assign ev_ma_sec  = ev_ma && !tgt_pri_q;

    a_r6_discard_removes: assert property (@(posedge clk) disable iff (!rst_n)
        post_discard |-> entry_remove);
    a_r3_limit_removes: assert property (@(posedge clk) disable iff (!rst_n)
        retry_limit_hit |-> (entry_remove && !retry_req));
    a_r10_idle_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rpt_claim);
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);
    a_r4_remove_idles: assert property (@(posedge clk) disable iff (!rst_n)
        entry_remove |-> !busy);
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_HOLD) && !rpt_valid) |=> ((st_q == ST_HOLD) && $stable(rpt_result)));
endmodule

// File: rtl/fth_status.sv
// Module: sticky per-bus master-abort status with write-one clear, plus the
// gated system-error pulse. Index 0 is the secondary bus and index 1 the primary.
// A setting event wins over a clear in the same cycle.
module fth_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_ma_pri,
    input  logic ev_ma_sec,
    input  logic ev_ma_post,
    input  logic ctl_ma_mode,
    input  logic ctl_serr_en,
    input  logic ctl_ma_post_dis,
    input  logic clr_pri,
    input  logic clr_sec,
    output logic sts_pri,
    output logic sts_sec,
    output logic serr_pulse
);
    localparam int N_SIDE = 2;

    logic [N_SIDE-1:0] ev_set, clr_w, sts_q;

    assign ev_set = {ev_ma_pri, ev_ma_sec};
    assign clr_w  = {clr_pri, clr_sec};

    generate
        for (genvar s = 0; s < N_SIDE; s++) begin : g_side
            // Sticky bit: set wins, write-one clears
            always_ff @(posedge clk) begin
                if (!rst_n)         sts_q[s] <= 1'b0;
                else if (ev_set[s]) sts_q[s] <= 1'b1;
                else if (clr_w[s])  sts_q[s] <= 1'b0;
            end

            a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                ev_set[s] |=> sts_q[s]);
            a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_q[s] && !clr_w[s]) |=> sts_q[s]);
        end
    endgenerate

    // One-cycle system error on a qualifying posted-write master abort
    always_ff @(posedge clk) begin
        if (!rst_n) serr_pulse <= 1'b0;
        else        serr_pulse <= ev_ma_post && ctl_ma_mode && ctl_serr_en && !ctl_ma_post_dis;
    end

    assign sts_pri = sts_q[1];
    assign sts_sec = sts_q[0];

    a_r8_serr_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> (sts_pri || sts_sec));
    a_r8_serr_single: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |=> !serr_pulse);
endmodule

// File: rtl/fwd_term_handler.sv
// Module: top of the forwarded-transaction termination handler. It ties the
// entry state machine, the bounded retry counter and the status block together.
// Assumes one entry is tracked at a time and the queue above issues loads.
module fwd_term_handler #(
    parameter int SHORT_LOG2 = 24,
    parameter int LONG_LOG2  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] load_kind,
    input  logic       load_tgt_pri,
    input  logic       load_long,
    input  logic       term_valid,
    input  logic [2:0] term_code,
    input  logic       rpt_valid,
    input  logic       ctl_ma_mode,
    input  logic       ctl_serr_en,
    input  logic       ctl_ma_post_dis,
    input  logic       sts_clr_pri,
    input  logic       sts_clr_sec,
    output logic       busy,
    output logic       retry_req,
    output logic       entry_remove,
    output logic       post_discard,
    output logic       retry_limit_hit,
    output logic       rpt_claim,
    output logic [2:0] rpt_result,
    output logic       sts_rma_pri,
    output logic       sts_rma_sec,
    output logic       serr_pulse
);
    logic ctr_clr, ctr_inc, at_limit;
    logic ev_ma_pri, ev_ma_sec, ev_ma_post;

    fth_decider u_decider (
        .clk, .rst_n, .load, .load_kind, .load_tgt_pri, .term_valid, .term_code,
        .rpt_valid, .at_limit, .ctr_clr, .ctr_inc, .busy, .retry_req, .entry_remove,
        .post_discard, .retry_limit_hit, .rpt_claim, .rpt_result,
        .ev_ma_pri, .ev_ma_sec, .ev_ma_post
    );

    fth_retry_ctr #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_ctr (
        .clk, .rst_n, .clr(ctr_clr), .sel_long_in(load_long), .inc(ctr_inc),
        .at_limit
    );

    fth_status u_status (
        .clk, .rst_n, .ev_ma_pri, .ev_ma_sec, .ev_ma_post, .ctl_ma_mode,
        .ctl_serr_en, .ctl_ma_post_dis, .clr_pri(sts_clr_pri), .clr_sec(sts_clr_sec),
        .sts_pri(sts_rma_pri), .sts_sec(sts_rma_sec), .serr_pulse
    );

    a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_req && entry_remove));
    a_r9_serr_posted_only: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> post_discard);
endmodule

// File: tb/test_fwd_term_handler.sv
// Bench: fixed-seed random transactions plus directed corner cases, with
// expected results computed from the requirements.
module test_fwd_term_handler;
    localparam int CLK_PERIOD = 10;
    localparam int SL2 = 3;
    localparam int LL2 = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic load = 0, load_tgt_pri = 0, load_long = 0, term_valid = 0, rpt_valid = 0;
    logic [1:0] load_kind = 0;
    logic [2:0] term_code = 0;
    logic ctl_ma_mode = 0, ctl_serr_en = 0, ctl_ma_post_dis = 0, sts_clr_pri = 0, sts_clr_sec = 0;
    logic busy, retry_req, entry_remove, post_discard, retry_limit_hit, rpt_claim;
    logic [2:0] rpt_result;
    logic sts_rma_pri, sts_rma_sec, serr_pulse;

    int n_chk = 0, n_fail = 0;
    bit m_pri = 0, m_sec = 0;

    fwd_term_handler #(.SHORT_LOG2(SL2), .LONG_LOG2(LL2)) i_fwd_term_handler (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(string req, bit rr, bit rem, bit dis, bit lim, bit se);
        chk(req, "retry_req", retry_req, rr);
        chk(req, "entry_remove", entry_remove, rem);
        chk(req, "post_discard", post_discard, dis);
        chk(req, "retry_limit_hit", retry_limit_hit, lim);
        chk(req, "serr_pulse", serr_pulse, se);
        chk(req, "sts_rma_pri", sts_rma_pri, m_pri);
        chk(req, "sts_rma_sec", sts_rma_sec, m_sec);
    endtask

    task automatic do_load(logic [1:0] k, bit pri, bit lng);
        load = 1; load_kind = k; load_tgt_pri = pri; load_long = lng;
        tick();
        load = 0;
        chk("R2", "busy after load", busy, 1);
    endtask

    task automatic do_term(logic [2:0] c);
        term_valid = 1; term_code = c;
        tick();
        term_valid = 0;
    endtask

    // Initiator repeat of a held completion: check response, then removal
    task automatic do_repeat(string req, bit claim, logic [2:0] res);
        rpt_valid = 1; #1;
        chk(req, "rpt_claim", rpt_claim, claim);
        chk(req, "rpt_result", rpt_result, res);
        tick();
        rpt_valid = 0;
        chk(req, "entry_remove after repeat", entry_remove, 1);
        chk(req, "busy after repeat", busy, 0);
    endtask

    task automatic clr_sts(bit p, bit s);
        sts_clr_pri = p; sts_clr_sec = s;
        tick();
        sts_clr_pri = 0; sts_clr_sec = 0;
        if (p) m_pri = 0;
        if (s) m_sec = 0;
        chk("R7", "pri after clear", sts_rma_pri, m_pri);
        chk("R7", "sec after clear", sts_rma_sec, m_sec);
    endtask

    // Full transaction: nret retries, then a final code; code 1 drives to the limit
    task automatic run_tx(logic [1:0] k, bit pri, bit lng, int nret, logic [2:0] fin,
                          bit mode, bit en, bit dis);
        int lim = lng ? (1 << LL2) : (1 << SL2);
        bit hold, claim, se, disc, rem;
        logic [2:0] res;
        ctl_ma_mode = mode; ctl_serr_en = en; ctl_ma_post_dis = dis;
        do_load(k, pri, lng);
        if (fin == 3'd1) nret = lim - 1;
        for (int i = 0; i < nret; i++) begin
            #1;
            chk("R10", "claim while issuing", rpt_claim, 1);
            chk("R10", "result while issuing", rpt_result, 1);
            do_term(3'd1);
            chk_out("R3", 1, 0, 0, 0, 0);
        end
        if (fin == 3'd1) begin
            do_term(3'd1);
            chk_out("R3", 0, 1, 0, 1, 0);
            chk("R3", "busy after limit", busy, 0);
            return;
        end
        hold = 0; claim = 0; se = 0; disc = 0; rem = 0; res = fin;
        if (fin == 3'd4) begin
            if (k == 2'd3) begin hold = 1; claim = 1; res = 3'd2; end
            else if (k == 2'd2) begin
                disc = 1; rem = 1; se = mode && en && !dis;
            end else begin hold = 1; claim = 0; end
            if (k != 2'd3) begin
                if (pri) m_pri = 1; else m_sec = 1;
            end
        end else begin
            if (k == 2'd2) rem = 1;
            else begin hold = 1; claim = 1; end
        end
        do_term(fin);
        chk_out(fin == 3'd4 ? (k == 2'd3 ? "R9" : (k == 2'd2 ? "R8" : "R5"))
                            : (k == 2'd2 ? "R6" : "R4"), 0, rem, disc, 0, se);
        if (k == 2'd2) chk("R6", "posted idle", busy, 0);
        if (hold) begin
            chk("R4", "held busy", busy, 1);
            do_repeat(fin == 3'd4 ? (k == 2'd3 ? "R9" : "R5") : "R4", claim, res);
        end
        tick();
        chk_out("R6", 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk_out("R1", 0, 0, 0, 0, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "rpt_claim", rpt_claim, 0);

        // R11 termination while idle ignored
        do_term(3'd4);
        chk_out("R11", 0, 0, 0, 0, 0);
        chk("R11", "idle busy", busy, 0);

        // R3 exact limit for both settings
        run_tx(2'd1, 1, 0, 0, 3'd1, 0, 0, 0);
        run_tx(2'd0, 0, 1, 0, 3'd1, 0, 0, 0);
        run_tx(2'd2, 0, 0, 0, 3'd1, 1, 1, 0);

        // R2 load while busy ignored: delayed read stays delayed, secondary side
        do_load(2'd0, 0, 0);
        load = 1; load_kind = 2'd2; load_tgt_pri = 1; tick(); load = 0;
        do_term(3'd4);
        m_sec = 1;
        chk_out("R2", 0, 0, 0, 0, 0);
        // R11 termination during hold ignored
        do_term(3'd1);
        chk_out("R11", 0, 0, 0, 0, 0);
        chk("R11", "still held", busy, 1);
        do_repeat("R5", 0, 3'd4);
        clr_sts(1, 1);

        // R7 set wins over clear in the same cycle
        do_load(2'd1, 1, 0);
        sts_clr_pri = 1;
        do_term(3'd4);
        sts_clr_pri = 0;
        m_pri = 1;
        chk("R7", "set wins", sts_rma_pri, 1);
        do_repeat("R5", 0, 3'd4);
        clr_sts(1, 0);

        // R8 every gate combination on a posted master abort
        for (int g = 0; g < 8; g++) begin
            run_tx(2'd2, g[0], 0, 0, 3'd4, g[2], g[1], g[0]);
            clr_sts(1, 1);
        end
        // R8/R9 no system error on delayed or special kinds
        run_tx(2'd0, 1, 0, 1, 3'd4, 1, 1, 0);
        run_tx(2'd3, 1, 0, 2, 3'd4, 1, 1, 0);
        clr_sts(1, 1);

        // Random mix over kinds and terminations
        for (int t = 0; t < 120; t++) begin
            logic [1:0] k = 2'($urandom_range(0, 3));
            int pick = $urandom_range(0, 9);
            logic [2:0] fin = (pick == 0) ? 3'd1 : (pick < 4) ? 3'd4 : 3'($urandom_range(0, 3) & 3);
            if (fin == 3'd1 && pick != 0) fin = 3'd0;
            run_tx(k, 1'($urandom), 1'($urandom_range(0, 4) == 0), $urandom_range(0, 3), fin,
                   1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) clr_sts(1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule